// File: doc/BRIEF.md
# Shared Memory Bank Lock Arbiter

This block guards one shared bank of 16-bit words on behalf of up to eight requesters, such as processor cores and coprocessors. A requester pulses its lock line to join a first-in first-out queue. The head of the queue owns the bank, and only the owner's address, data and strobe inputs reach the storage array. When the owner pulses its unlock line, the next waiter takes ownership on the following cycle, so there is no idle cycle between owners.

Every access by the owner is checked against two static sixteen-bit permission masks, one for reads and one for writes, with one bit per page. The page number is the top four address bits. A denied access gives a one-cycle error pulse. One contiguous range of pages, given by a first page and a last page, is sent to a memory-mapped device interface instead of the storage array.

The address width is a parameter. The production setting is 16 bits, which gives 64K words in 4K-word pages. The default of 10 bits keeps the array small for elaboration.

Top module: `bank_lock_arbiter`

## Requirements
- R1: After reset no grant is asserted, and rvalid_o, err_o, dev_rd_o and dev_wr_o are low.
- R2: A lock pulse from a requester while the queue is empty makes grant_o one-hot for that requester on the next cycle.
- R3: Ownership passes in order of arrival. Requesters whose lock pulses fall in the same cycle are queued by ascending index.
- R4: An unlock pulse from the owner in cycle t grants the next waiter in cycle t+1, or leaves grant_o zero if nobody waits. An unlock pulse from a requester that is not the owner has no effect on grant_o.
- R5: A lock pulse from a requester that already owns the bank or is already queued is ignored, so each requester holds at most one queue entry.
- R6: The rd_i, wr_i, addr_i and wdata_i inputs of a requester that is not the owner have no effect. They cause no write, no read response and no error.
- R7: An owner read from a readable page outside the mapped range returns the stored word on rdata_o with rvalid_o high on the next cycle, with err_o low.
- R8: The page is addr[AW-1:AW-4]. A read from a page whose rd_mask_i bit is 0 gives rvalid_o and err_o high on the next cycle, with rdata_o equal to 0.
- R9: A write to a page whose wr_mask_i bit is 0 leaves the storage array and the device untouched, and gives err_o high with rvalid_o low on the next cycle.
- R10: An owner access to a page p with map_first_i <= p <= map_last_i drives dev_rd_o or dev_wr_o in the same cycle, with dev_addr_o and dev_wdata_o taken from the owner. It does not touch the storage array. A mapped read returns the dev_rdata_i value of the access cycle on rdata_o on the next cycle. If map_first_i > map_last_i, no page is mapped.
- R11: If rd_i and wr_i are both high for the owner, only the write is performed and no read response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | N_REQ | Per-requester lock request pulse |
| unlock_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | One-hot current owner |
| rd_i | input | N_REQ | Per-requester read strobe |
| wr_i | input | N_REQ | Per-requester write strobe |
| addr_i | input | N_REQ*AW | Packed per-requester word addresses |
| wdata_i | input | N_REQ*DW | Packed per-requester write data |
| rdata_o | output | DW | Read data, one cycle after the access |
| rvalid_o | output | 1 | Read response pulse |
| err_o | output | 1 | Permission-denied pulse, one cycle after the access |
| rd_mask_i | input | 16 | Per-page read permission |
| wr_mask_i | input | 16 | Per-page write permission |
| map_first_i | input | 4 | First page of the mapped device range |
| map_last_i | input | 4 | Last page of the mapped device range |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wr_o | output | 1 | Device write strobe |
| dev_addr_o | output | AW | Device address |
| dev_wdata_o | output | DW | Device write data |
| dev_rdata_i | input | DW | Device read data, valid in the access cycle |

## Verification
Two functions can fall in the same cycle: the queue receiving a lock pulse, and the owner releasing the bank. Both can also meet an access from a requester that is still blocked. The bench provokes this by raising lock pulses from several requesters together, including one from the current owner. It then sends an unlock from a waiter before the real release. It judges the result by the grant sequence at the ports, cycle by cycle, and by the queue draining to zero without a second entry for the owner. Blocked-requester traffic is judged by the scoreboard receiving no response, and by later reads showing that memory is unchanged.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  localparam int PAGE_BITS = 4;
  localparam int N_PAGES   = 1 << PAGE_BITS;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_DEV   = 2'd2
  } rsrc_e;
endpackage

// File: rtl/lock_queue.sv
module lock_queue #(
  parameter int N_REQ = 8,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int CW = $clog2(N_REQ + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] lock_i,
  input  logic [N_REQ-1:0] unlock_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             owner_valid_o,
  output logic [IW-1:0]    owner_idx_o
);
  logic [IW-1:0]    slot_q [N_REQ];
  logic [IW-1:0]    slot_n [N_REQ];
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [N_REQ-1:0] member_q, member_n;
  logic [N_REQ-1:0] push_vec;
  logic             pop;

  assign owner_valid_o = (cnt_q != '0);
  assign owner_idx_o   = slot_q[0];
  assign grant_o       = owner_valid_o ? (N_REQ'(1) << slot_q[0]) : '0;
  assign pop           = owner_valid_o && unlock_i[slot_q[0]];
  // queued or owning requesters may not take a second entry
  assign push_vec      = lock_i & ~member_q;

  always_comb begin
    int pos;
    for (int i = 0; i < N_REQ; i++) begin
      if (pop) slot_n[i] = (i < N_REQ - 1) ? slot_q[(i + 1) % N_REQ] : '0;
      else     slot_n[i] = slot_q[i];
    end
    pos = int'(cnt_q) - (pop ? 1 : 0);
    for (int r = 0; r < N_REQ; r++) begin
      if (push_vec[r] && pos < N_REQ) begin
        slot_n[pos] = IW'(r);
        pos = pos + 1;
      end
    end
    cnt_n    = CW'(pos);
    member_n = (member_q & ~(pop ? grant_o : '0)) | push_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      member_q <= '0;
      for (int i = 0; i < N_REQ; i++) slot_q[i] <= '0;
    end else begin
      cnt_q    <= cnt_n;
      member_q <= member_n;
      for (int i = 0; i < N_REQ; i++) slot_q[i] <= slot_n[i];
    end
  end

  p_grant_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_handoff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && cnt_q > CW'(1)) |=> owner_valid_o);
  p_hold_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_valid_o && !pop) |=> (grant_o == $past(grant_o)));
  p_single_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == $countones(member_q));
endmodule

// File: rtl/perm_check.sv
module perm_check
  import bank_arb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0]        addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [N_PAGES-1:0]   rd_mask_i,
  input  logic [N_PAGES-1:0]   wr_mask_i,
  input  logic [PAGE_BITS-1:0] map_first_i,
  input  logic [PAGE_BITS-1:0] map_last_i,
  output logic [PAGE_BITS-1:0] page_o,
  output logic                 rd_eff_o,
  output logic                 allow_rd_o,
  output logic                 allow_wr_o,
  output logic                 deny_o,
  output logic                 in_map_o
);
  assign page_o     = addr_i[AW-1 -: PAGE_BITS];
  assign rd_eff_o   = rd_i & ~wr_i;  // write wins
  assign allow_rd_o = rd_eff_o & rd_mask_i[page_o];
  assign allow_wr_o = wr_i & wr_mask_i[page_o];
  assign deny_o     = (rd_eff_o & ~rd_mask_i[page_o]) | (wr_i & ~wr_mask_i[page_o]);
  assign in_map_o   = (page_o >= map_first_i) && (page_o <= map_last_i);
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bank_lock_arbiter.sv
module bank_lock_arbiter
  import bank_arb_pkg::*;
#(
  parameter int N_REQ = 8,
  parameter int AW    = 10,
  parameter int DW    = 16,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_REQ-1:0]     lock_i,
  input  logic [N_REQ-1:0]     unlock_i,
  output logic [N_REQ-1:0]     grant_o,
  input  logic [N_REQ-1:0]     rd_i,
  input  logic [N_REQ-1:0]     wr_i,
  input  logic [N_REQ*AW-1:0]  addr_i,
  input  logic [N_REQ*DW-1:0]  wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 rvalid_o,
  output logic                 err_o,
  input  logic [N_PAGES-1:0]   rd_mask_i,
  input  logic [N_PAGES-1:0]   wr_mask_i,
  input  logic [PAGE_BITS-1:0] map_first_i,
  input  logic [PAGE_BITS-1:0] map_last_i,
  output logic                 dev_rd_o,
  output logic                 dev_wr_o,
  output logic [AW-1:0]        dev_addr_o,
  output logic [DW-1:0]        dev_wdata_o,
  input  logic [DW-1:0]        dev_rdata_i
);
  logic                 owner_valid;
  logic [IW-1:0]        owner_idx;
  logic                 acc_rd, acc_wr;
  logic [AW-1:0]        bus_addr;
  logic [DW-1:0]        bus_wdata;
  logic [PAGE_BITS-1:0] page;
  logic                 rd_eff, allow_rd, allow_wr, deny, in_map;
  logic                 store_we, store_re;
  logic [DW-1:0]        store_rdata;
  logic                 rvalid_q, err_q;
  rsrc_e                src_q;
  logic [DW-1:0]        dev_data_q;

  lock_queue #(.N_REQ(N_REQ)) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock_i),
    .unlock_i     (unlock_i),
    .grant_o      (grant_o),
    .owner_valid_o(owner_valid),
    .owner_idx_o  (owner_idx)
  );

  // only the owner's bus reaches the bank
  assign acc_rd    = owner_valid & rd_i[owner_idx];
  assign acc_wr    = owner_valid & wr_i[owner_idx];
  assign bus_addr  = addr_i[int'(owner_idx)*AW +: AW];
  assign bus_wdata = wdata_i[int'(owner_idx)*DW +: DW];

  perm_check #(.AW(AW)) u_perm (
    .addr_i     (bus_addr),
    .rd_i       (acc_rd),
    .wr_i       (acc_wr),
    .rd_mask_i  (rd_mask_i),
    .wr_mask_i  (wr_mask_i),
    .map_first_i(map_first_i),
    .map_last_i (map_last_i),
    .page_o     (page),
    .rd_eff_o   (rd_eff),
    .allow_rd_o (allow_rd),
    .allow_wr_o (allow_wr),
    .deny_o     (deny),
    .in_map_o   (in_map)
  );

  assign store_we    = allow_wr & ~in_map;
  assign store_re    = allow_rd & ~in_map;
  assign dev_wr_o    = allow_wr & in_map;
  assign dev_rd_o    = allow_rd & in_map;
  assign dev_addr_o  = bus_addr;
  assign dev_wdata_o = bus_wdata;

  bank_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i  (clk_i),
    .we_i   (store_we),
    .re_i   (store_re),
    .addr_i (bus_addr),
    .wdata_i(bus_wdata),
    .rdata_o(store_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      err_q      <= 1'b0;
      src_q      <= SRC_NONE;
      dev_data_q <= '0;
    end else begin
      rvalid_q <= rd_eff;
      err_q    <= deny;
      if (allow_rd) src_q <= in_map ? SRC_DEV : SRC_STORE;
      else          src_q <= SRC_NONE;
      if (dev_rd_o) dev_data_q <= dev_rdata_i;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_STORE: rdata_o = store_rdata;
      SRC_DEV:   rdata_o = dev_data_q;
      default:   rdata_o = '0;
    endcase
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

  p_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_we || dev_wr_o || dev_rd_o) |-> (grant_o != '0));
  p_read_resp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && !acc_wr) |=> rvalid_o);
  p_denied_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && !acc_wr && !rd_mask_i[page]) |=> (err_o && rvalid_o && rdata_o == '0));
  p_denied_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && !wr_mask_i[page]) |-> (!store_we && !dev_wr_o));
  p_dev_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_o || dev_wr_o) |-> (page >= map_first_i && page <= map_last_i));
  p_write_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && acc_wr) |=> !rvalid_o);
endmodule

// File: tb/bank_lock_arbiter_tb.sv
module bank_lock_arbiter_tb;
  localparam int N  = 8;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lock_i = '0, unlock_i = '0, grant_o;
  logic [N-1:0]  rd_i = '0, wr_i = '0;
  logic [N*AW-1:0] addr_i = '0;
  logic [N*DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, err_o;
  logic [15:0]   rd_mask = 16'hFF7F, wr_mask = 16'hFFFF;
  logic [3:0]    map_first = 4'd15, map_last = 4'd14;
  logic          dev_rd_o, dev_wr_o;
  logic [AW-1:0] dev_addr_o;
  logic [DW-1:0] dev_wdata_o, dev_rdata;

  int total = 0, bad = 0;
  int owner_m = -1;
  logic [DW-1:0] mem_m [1 << AW];

  typedef struct packed { logic [DW-1:0] d; logic rv; logic er; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz
  assign dev_rdata = DW'(dev_addr_o) ^ 16'hA5A5;

  bank_lock_arbiter #(.N_REQ(N), .AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock_i), .unlock_i(unlock_i),
    .grant_o(grant_o), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
    .rd_mask_i(rd_mask), .wr_mask_i(wr_mask), .map_first_i(map_first),
    .map_last_i(map_last), .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o),
    .dev_addr_o(dev_addr_o), .dev_wdata_o(dev_wdata_o), .dev_rdata_i(dev_rdata)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every response is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (rvalid_o || err_o)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected response", {rvalid_o, err_o, rdata_o}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rvalid_o == e.rv && err_o == e.er && (!e.rv || rdata_o === e.d),
              "R7/R8/R9/R10 response", {14'h0, rvalid_o, err_o, rdata_o},
              {14'h0, e.rv, e.er, e.d});
      end
    end
  end

  task automatic lock_pulse(logic [N-1:0] l, logic [N-1:0] u);
    @(negedge clk);
    lock_i = l; unlock_i = u;
    @(negedge clk);
    lock_i = '0; unlock_i = '0;
  endtask

  task automatic access(int who, bit r, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit chk_dev);
    logic [3:0] pg;
    bit mapped;
    exp_t e;
    pg = a[AW-1 -: 4];
    mapped = (pg >= map_first) && (pg <= map_last);
    if (who == owner_m) begin
      if (w) begin
        if (!wr_mask[pg]) begin
          e = '{d: '0, rv: 1'b0, er: 1'b1}; exp_q.push_back(e);
        end else if (!mapped) mem_m[a] = d;
      end else if (r) begin
        if (!rd_mask[pg]) e = '{d: '0, rv: 1'b1, er: 1'b1};
        else if (mapped)  e = '{d: DW'(a) ^ 16'hA5A5, rv: 1'b1, er: 1'b0};
        else              e = '{d: mem_m[a], rv: 1'b1, er: 1'b0};
        exp_q.push_back(e);
      end
    end
    @(negedge clk);
    rd_i[who] = r; wr_i[who] = w;
    addr_i[who*AW +: AW] = a; wdata_i[who*DW +: DW] = d;
    #1;
    if (chk_dev) begin
      check(dev_wr_o == (w && mapped) && dev_rd_o == (r && !w && mapped),
            "R10 device strobes", {dev_rd_o, dev_wr_o}, {(r && !w && mapped), (w && mapped)});
      if (mapped)
        check(dev_addr_o == a && (!w || dev_wdata_o == d), "R10 device bus",
              {dev_addr_o, dev_wdata_o}, {a, d});
    end
    @(negedge clk);
    rd_i[who] = 1'b0; wr_i[who] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(grant_o == '0 && !rvalid_o && !err_o && !dev_rd_o && !dev_wr_o,
          "R1 reset state", {grant_o, rvalid_o, err_o, dev_rd_o, dev_wr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    lock_pulse(8'h04, '0); owner_m = 2;
    check(grant_o == 8'h04, "R2 first grant", grant_o, 8'h04);

    access(2, 0, 1, 10'h010, 16'h1234, 1);
    access(2, 1, 0, 10'h010, 16'h0, 1);            // R7
    access(5, 1, 1, 10'h010, 16'hDEAD, 1);         // R6 blocked requester
    access(5, 1, 0, 10'h1C0, 16'h0, 0);            // R6 blocked denied read
    access(2, 1, 0, 10'h010, 16'h0, 0);            // R6 memory unchanged

    lock_pulse(8'h2C, '0);                         // 5,3 together; owner 2 again (R5)
    lock_pulse(8'h02, 8'h08);                      // 1 joins; unlock from waiter 3
    check(grant_o == 8'h04, "R4 non-owner unlock ignored", grant_o, 8'h04);
    lock_pulse('0, 8'h04);
    check(grant_o == 8'h08, "R3 R4 hand-off to lowest simultaneous", grant_o, 8'h08);
    lock_pulse('0, 8'h08);
    check(grant_o == 8'h20, "R3 second simultaneous", grant_o, 8'h20);
    lock_pulse('0, 8'h20);
    check(grant_o == 8'h02, "R3 later arrival", grant_o, 8'h02);
    lock_pulse('0, 8'h02);
    check(grant_o == 8'h00, "R5 no duplicate entry", grant_o, 8'h00);

    lock_pulse(8'h01, '0); owner_m = 0;
    check(grant_o == 8'h01, "R2 regrant", grant_o, 8'h01);

    access(0, 1, 0, 10'h1C0, 16'h0, 0);            // R8 page 7 unreadable
    access(0, 0, 1, 10'h140, 16'h5555, 0);
    wr_mask = 16'hFFDF;
    access(0, 0, 1, 10'h140, 16'hBAD0, 1);         // R9 denied write
    access(0, 1, 0, 10'h140, 16'h0, 0);            // R9 old value kept

    access(0, 0, 1, 10'h300, 16'h1111, 1);         // R10 map disabled
    map_first = 4'd12; map_last = 4'd13;
    access(0, 0, 1, 10'h300, 16'h7777, 1);         // R10 device write
    access(0, 1, 0, 10'h344, 16'h0, 1);            // R10 device read
    map_first = 4'd15; map_last = 4'd14;
    access(0, 1, 0, 10'h300, 16'h0, 1);            // R10 store untouched

    access(0, 1, 1, 10'h020, 16'h4444, 0);         // R11 write only
    access(0, 1, 0, 10'h020, 16'h0, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule